// File: doc/BRIEF.md
# DDS Serial Programming Controller

This block drives the configuration pins of a direct digital synthesizer from inside a chip. The link has four lines: a device reset, a data line, a write clock and a frequency-update strobe. An init request sends a reset pulse. A single write-clock pulse follows, then a single update strobe, and together these put the synthesizer into serial load mode. After that, each update request takes a 32-bit tuning word, a phase value and a power-down flag. The controller packs them into a 40-bit frame, sends it one bit per write-clock pulse, and latches it with one update strobe.

Pulse timing is set at run time by two counts, given in system clock cycles. One sets how long a strobe stays high. The other sets how long a line stays low before the next strobe rises. A count of zero is treated as one. Both counts are captured when a request is accepted, so the device timing minimums can be met at any system clock rate. The controller refuses an update that arrives before init has completed, while a sequence is running, or with a phase value that does not fit in five bits. It signals each refusal with a one-cycle error pulse and sends nothing.

Top module: `dds_serial_ctrl`

## Requirements
- R1: After synchronous reset, busy, ready, err and all four serial outputs (dds_reset, dds_wclk, dds_fqud, dds_data) are low. While busy is low, all four serial outputs stay low.
- R2: An accepted init request clears ready. It then produces exactly one dds_reset pulse, then one dds_wclk pulse, then one dds_fqud pulse, in that order, with dds_data held low. Ready is high once busy falls.
- R3: An update sends exactly 40 bits, least significant first. Each bit is sampled on a dds_wclk rising edge, and dds_data is already stable on the cycle before that edge. Frame bits 0 to 31 carry the tuning word in its own bit order, so the lowest byte goes first.
- R4: Frame bits 32 and 33 are always 0. Bit 34 is the power-down flag, and bits 35 to 39 carry phase bits 0 to 4.
- R5: Exactly one dds_fqud pulse follows an update, and it starts only after the 40th dds_wclk pulse.
- R6: Every high pulse on dds_reset, dds_wclk and dds_fqud lasts max(hi_cycles,1) clocks. Before every dds_wclk rise, and before the update strobe, the write clock has been low for max(lo_cycles,1) clocks. At most one of these three lines is high at any time.
- R7: Busy rises on the clock edge that accepts a request. It stays high until max(lo_cycles,1) clocks after the last strobe falls.
- R8: An update request made before init completes is ignored. It gives a one-cycle err pulse and no serial activity.
- R9: An update request made while busy is ignored. It raises err for one cycle and does not change the frame in flight.
- R10: An update whose phase_req is above 31 is rejected with err, and nothing is sent. Ready stays high.
- R11: An init request made while busy is ignored, and no reset pulse is produced.
- R12: A synchronous reset during a transfer returns the controller to the uninitialized idle state: outputs low, ready low. A later update is refused with err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| init_req | input | 1 | Request the reset and serial-mode entry sequence |
| upd_req | input | 1 | Request a frame update |
| tune_word | input | TW_W (32) | Tuning word for the update |
| phase_req | input | PHIN_W (8) | Requested phase; values above 31 are rejected |
| pwr_down | input | 1 | Power-down flag placed in the frame |
| hi_cycles | input | CNT_W (8) | Strobe high time in clocks (0 treated as 1) |
| lo_cycles | input | CNT_W (8) | Low/setup time in clocks (0 treated as 1) |
| busy | output | 1 | A sequence is in progress |
| ready | output | 1 | Init has completed; updates are accepted |
| err | output | 1 | One-cycle pulse on a refused update |
| dds_reset | output | 1 | Device reset line |
| dds_wclk | output | 1 | Device write clock |
| dds_fqud | output | 1 | Device frequency-update strobe |
| dds_data | output | 1 | Device serial data |

## Verification
A wrong sequencer state appears at the pins within one pulse period. It shows up as a strobe on the wrong line, a pulse that is too long or too short, or an update strobe that arrives before the fortieth write-clock edge. A shift register or bit counter that is out of step shows up as a frame, rebuilt from the data line at each write-clock rise, that no longer matches the packed inputs. It can also show up as a bit count other than forty. A wrong ready or acceptance state appears one clock after a request, as a missing or extra err pulse, or as serial activity where none should occur.

// File: rtl/dds_ctrl_pkg.sv
package dds_ctrl_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_RST_H, S_RST_L,
    S_MW_H,  S_MW_L,
    S_MF_H,  S_MF_L,
    S_BIT_L, S_BIT_H,
    S_GAP,   S_FQ_H,  S_TAIL
  } seq_st_t;

  // States whose duration is the high-pulse count
  function automatic logic st_is_high(input seq_st_t s);
    return (s == S_RST_H) || (s == S_MW_H) || (s == S_MF_H) ||
           (s == S_BIT_H) || (s == S_FQ_H);
  endfunction

endpackage

// File: rtl/dds_frame_pack.sv
module dds_frame_pack #(
  parameter int TW_W = 32,
  parameter int PH_W = 5,
  localparam int CTRL_W  = 2,
  localparam int FRAME_W = TW_W + CTRL_W + 1 + PH_W
) (
  input  logic [TW_W-1:0]    tw,
  input  logic [PH_W-1:0]    ph,
  input  logic               pd,
  output logic [FRAME_W-1:0] frame
);
  // Control bits are forced to zero regardless of any input
  always_comb frame = {ph, pd, {CTRL_W{1'b0}}, tw};
endmodule

// File: rtl/dds_pulse_timer.sv
module dds_pulse_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (load)          cnt <= load_val;
    else if (cnt != '0)     cnt <= cnt - CNT_W'(1);
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/dds_serial_ctrl.sv
module dds_serial_ctrl
  import dds_ctrl_pkg::*;
#(
  parameter int TW_W   = 32,
  parameter int PH_W   = 5,
  parameter int PHIN_W = 8,
  parameter int CNT_W  = 8,
  localparam int FRAME_W = TW_W + 3 + PH_W,
  localparam int BC_W    = $clog2(FRAME_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_req,
  input  logic              upd_req,
  input  logic [TW_W-1:0]   tune_word,
  input  logic [PHIN_W-1:0] phase_req,
  input  logic              pwr_down,
  input  logic [CNT_W-1:0]  hi_cycles,
  input  logic [CNT_W-1:0]  lo_cycles,
  output logic              busy,
  output logic              ready,
  output logic              err,
  output logic              dds_reset,
  output logic              dds_wclk,
  output logic              dds_fqud,
  output logic              dds_data
);

  function automatic logic [CNT_W-1:0] at_least1(input logic [CNT_W-1:0] v);
    return (v == '0) ? CNT_W'(1) : v;
  endfunction

  seq_st_t state, state_n;
  logic [CNT_W-1:0]   hi_q, lo_q, dur_h, dur_l, tmr_val;
  logic [BC_W-1:0]    bitcnt;
  logic [FRAME_W-1:0] shreg, shreg_n, frame;
  logic phase_ok, accept_init, accept_upd, accept, upd_rej;
  logic tmr_exp, adv, last_bit, tmr_load;

  dds_frame_pack #(.TW_W(TW_W), .PH_W(PH_W)) u_pack (
    .tw(tune_word), .ph(phase_req[PH_W-1:0]), .pd(pwr_down), .frame(frame)
  );

  dds_pulse_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
  );

  assign phase_ok    = ((phase_req >> PH_W) == '0);
  assign accept_init = init_req && (state == S_IDLE);
  assign accept_upd  = upd_req && !init_req && (state == S_IDLE) && ready && phase_ok;
  assign accept      = accept_init || accept_upd;
  assign upd_rej     = upd_req && !accept_upd;
  assign adv         = (state != S_IDLE) && tmr_exp;
  assign last_bit    = (bitcnt == BC_W'(FRAME_W-1));

  always_comb begin
    state_n = state;
    if (accept_init)      state_n = S_RST_H;
    else if (accept_upd)  state_n = S_BIT_L;
    else if (adv) begin
      case (state)
        S_RST_H: state_n = S_RST_L;
        S_RST_L: state_n = S_MW_H;
        S_MW_H:  state_n = S_MW_L;
        S_MW_L:  state_n = S_MF_H;
        S_MF_H:  state_n = S_MF_L;
        S_MF_L:  state_n = S_IDLE;
        S_BIT_L: state_n = S_BIT_H;
        S_BIT_H: state_n = last_bit ? S_GAP : S_BIT_L;
        S_GAP:   state_n = S_FQ_H;
        S_FQ_H:  state_n = S_TAIL;
        S_TAIL:  state_n = S_IDLE;
        default: state_n = S_IDLE;
      endcase
    end
  end

  // Counts are taken from the ports on the accepting edge, then held
  assign dur_h    = accept ? at_least1(hi_cycles) : hi_q;
  assign dur_l    = accept ? at_least1(lo_cycles) : lo_q;
  assign tmr_load = accept || adv;
  assign tmr_val  = st_is_high(state_n) ? (dur_h - CNT_W'(1)) : (dur_l - CNT_W'(1));

  always_comb begin
    if (accept_upd)                                  shreg_n = frame;
    else if (adv && (state == S_BIT_H) && !last_bit) shreg_n = shreg >> 1;
    else                                             shreg_n = shreg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      hi_q      <= CNT_W'(1);
      lo_q      <= CNT_W'(1);
      bitcnt    <= '0;
      shreg     <= '0;
      ready     <= 1'b0;
      busy      <= 1'b0;
      err       <= 1'b0;
      dds_reset <= 1'b0;
      dds_wclk  <= 1'b0;
      dds_fqud  <= 1'b0;
      dds_data  <= 1'b0;
    end else begin
      state <= state_n;
      shreg <= shreg_n;
      if (accept) begin
        hi_q <= dur_h;
        lo_q <= dur_l;
      end
      if (accept_init)                      ready <= 1'b0;
      else if (adv && (state == S_MF_L))    ready <= 1'b1;
      if (accept_upd)                                    bitcnt <= '0;
      else if (adv && (state == S_BIT_H) && !last_bit)   bitcnt <= bitcnt + BC_W'(1);
      busy      <= (state_n != S_IDLE);
      err       <= upd_rej;
      dds_reset <= (state_n == S_RST_H);
      dds_wclk  <= (state_n == S_MW_H) || (state_n == S_BIT_H);
      dds_fqud  <= (state_n == S_MF_H) || (state_n == S_FQ_H);
      dds_data  <= ((state_n == S_BIT_L) || (state_n == S_BIT_H)) ? shreg_n[0] : 1'b0;
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !(dds_reset || dds_wclk || dds_fqud || dds_data));

  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({dds_reset, dds_wclk, dds_fqud}));

  // R3
  data_setup_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dds_wclk) |-> $stable(dds_data));

  // R8
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> $past(upd_req));

  // R2
  ready_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dds_reset) |-> !ready);

  // R5
  fqud_after_frame_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(dds_fqud) && ready) |-> last_bit);

endmodule

// File: tb/dds_serial_ctrl_test.sv
`timescale 1ns/1ps
module dds_serial_ctrl_test;

  logic clk = 1'b0, rst = 1'b1;
  logic init_req = 0, upd_req = 0, pwr_down = 0;
  logic [31:0] tune_word = '0;
  logic [7:0]  phase_req = '0, hi_cycles = 8'd1, lo_cycles = 8'd1;
  logic busy, ready, err, dds_reset, dds_wclk, dds_fqud, dds_data;

  int n_tests = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  dds_serial_ctrl uut (
    .clk(clk), .rst(rst), .init_req(init_req), .upd_req(upd_req),
    .tune_word(tune_word), .phase_req(phase_req), .pwr_down(pwr_down),
    .hi_cycles(hi_cycles), .lo_cycles(lo_cycles),
    .busy(busy), .ready(ready), .err(err),
    .dds_reset(dds_reset), .dds_wclk(dds_wclk), .dds_fqud(dds_fqud), .dds_data(dds_data)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [39:0] exp_frame(input logic [31:0] tw, input logic [4:0] ph,
                                            input logic pd);
    logic [39:0] f;
    f[31:0] = tw; f[32] = 1'b0; f[33] = 1'b0; f[34] = pd; f[39:35] = ph;
    return f;
  endfunction

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL ALL watchdog expired: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  // Issues a request and observes the serial lines until busy falls
  task automatic run_seq(input bit is_init, input logic [31:0] tw, input logic [7:0] ph,
                         input bit pd, input int hc, input int lc, input bit inject);
    int H, L, n, wrise, frise, rrise, seq, whi, fhi, rhi, wlo, tail, errs;
    int bad_hi, bad_lo, gap_bad;
    bit prev_w, prev_f, prev_r, fq_early, data_bad, ffell, first_busy;
    logic [39:0] got;
    H = (hc == 0) ? 1 : hc;
    L = (lc == 0) ? 1 : lc;
    n = 0; wrise = 0; frise = 0; rrise = 0; seq = 0; whi = 0; fhi = 0; rhi = 0;
    wlo = 0; tail = 0; errs = 0; bad_hi = 0; bad_lo = 0; gap_bad = 0;
    prev_w = 0; prev_f = 0; prev_r = 0; fq_early = 0; data_bad = 0; ffell = 0;
    got = '0; first_busy = 0;
    tune_word = tw; phase_req = ph; pwr_down = pd;
    hi_cycles = 8'(hc); lo_cycles = 8'(lc);
    if (is_init) init_req = 1'b1; else upd_req = 1'b1;
    @(posedge clk); #1;
    init_req = 1'b0; upd_req = 1'b0;
    while (n < 3000) begin
      @(negedge clk);
      n++;
      if (n == 1) first_busy = busy;
      if (err) errs++;
      if (is_init && dds_data) data_bad = 1;
      // write clock
      if (dds_wclk && !prev_w) begin
        wrise++;
        seq = seq * 10 + 2;
        if (wrise <= 40) got[wrise-1] = dds_data;
        if (!is_init && wlo != L) bad_lo++;
      end
      if (dds_wclk) begin whi++; wlo = 0; end
      else begin
        if (prev_w) begin if (whi != H) bad_hi++; whi = 0; end
        wlo++;
      end
      // update strobe
      if (dds_fqud && !prev_f) begin
        frise++;
        seq = seq * 10 + 3;
        if (!is_init && wrise != 40) fq_early = 1;
        if (!is_init && (wlo - 1) != L) gap_bad++;
      end
      if (dds_fqud) fhi++;
      else if (prev_f) begin if (fhi != H) bad_hi++; fhi = 0; ffell = 1; end
      if (ffell && !dds_fqud && busy) tail++;
      // device reset
      if (dds_reset && !prev_r) begin rrise++; seq = seq * 10 + 1; end
      if (dds_reset) rhi++;
      else if (prev_r) begin if (rhi != H) bad_hi++; rhi = 0; end
      prev_w = dds_wclk; prev_f = dds_fqud; prev_r = dds_reset;
      if (inject && n == 5) begin
        upd_req = 1'b1; init_req = 1'b1; tune_word = ~tw; phase_req = 8'd3; pwr_down = ~pd;
      end
      if (inject && n == 6) begin
        upd_req = 1'b0; init_req = 1'b0;
      end
      if (!busy) break;
    end
    check(first_busy == 1, "R7", "busy after accept", first_busy, 1);
    check(bad_hi == 0, "R6", "high pulse widths off", bad_hi, 0);
    check(tail == L, "R7", "busy tail after strobe", tail, L);
    if (is_init) begin
      check(seq == 123, "R2", "init pulse order", seq, 123);
      check(data_bad == 0, "R2", "data during init", data_bad, 0);
      check(ready == 1, "R2", "ready after init", ready, 1);
    end else begin
      check(wrise == 40, "R3", "write clock count", wrise, 40);
      check(got[31:0] == tw, "R3", "tuning word bits", got[31:0], tw);
      check(got[39:32] == exp_frame(tw, ph[4:0], pd)[39:32], "R4", "control/phase byte",
            got[39:32], exp_frame(tw, ph[4:0], pd)[39:32]);
      check(frise == 1 && !fq_early, "R5", "strobe count/order", frise, 1);
      check(bad_lo == 0 && gap_bad == 0, "R6", "low/setup widths off", bad_lo + gap_bad, 0);
      if (inject) begin
        check(errs == 1, "R9", "err pulses for busy update", errs, 1);
        check(rrise == 0, "R11", "reset pulses for busy init", rrise, 0);
      end else begin
        check(errs == 0, "R9", "unexpected err", errs, 0);
      end
    end
  endtask

  task automatic reject_chk(input string req, input logic [7:0] ph);
    bit quiet;
    tune_word = 32'h1357_9bdf; phase_req = ph;
    upd_req = 1'b1;
    @(posedge clk); #1 upd_req = 1'b0;
    @(negedge clk);
    check(err == 1, req, "err on refused update", err, 1);
    check(busy == 0, req, "busy after refused update", busy, 0);
    quiet = 1;
    repeat (4) begin
      @(negedge clk);
      if (dds_wclk || dds_fqud || dds_data || dds_reset || busy || err) quiet = 0;
    end
    check(quiet, req, "activity after refused update", quiet, 1);
    @(posedge clk); #1;
  endtask

  initial begin
    void'($urandom(32'h5eed_0011));
    do_reset();
    @(negedge clk);
    check({busy, ready, err, dds_reset, dds_wclk, dds_fqud, dds_data} == 7'b0,
          "R1", "outputs after reset",
          {busy, ready, err, dds_reset, dds_wclk, dds_fqud, dds_data}, 0);
    @(posedge clk); #1;

    reject_chk("R8", 8'd4);

    run_seq(1, 0, 0, 0, 1, 1, 0);
    run_seq(1, 0, 0, 0, 0, 2, 0);

    run_seq(0, 32'h0000_0001, 8'd31, 1, 1, 1, 0);
    run_seq(0, 32'hFFFF_FFFF, 8'd0,  0, 3, 2, 0);
    run_seq(0, 32'hA5C3_0F81, 8'd21, 1, 0, 0, 0);

    reject_chk("R10", 8'd32);
    reject_chk("R10", 8'd255);
    @(negedge clk);
    check(ready == 1, "R10", "ready kept after phase reject", ready, 1);
    @(posedge clk); #1;

    for (int i = 0; i < 6; i++) begin
      logic [31:0] tw;
      logic [7:0]  ph;
      tw = $urandom;
      ph = 8'($urandom % 32);
      run_seq(0, tw, ph, 1'($urandom % 2), int'($urandom % 4), int'($urandom % 4), 0);
    end

    run_seq(0, 32'h6C1E_93B4, 8'd9, 0, 2, 1, 1);

    // R12: reset mid-transfer
    tune_word = 32'hDEAD_BEEF; phase_req = 8'd5; hi_cycles = 8'd2; lo_cycles = 8'd2;
    upd_req = 1'b1;
    @(posedge clk); #1 upd_req = 1'b0;
    repeat (30) @(posedge clk);
    #1 rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    check({busy, ready, dds_reset, dds_wclk, dds_fqud, dds_data} == 6'b0, "R12",
          "outputs after mid-transfer reset",
          {busy, ready, dds_reset, dds_wclk, dds_fqud, dds_data}, 0);
    @(posedge clk); #1;
    reject_chk("R12", 8'd1);

    finish_run();
  end

endmodule